// File: doc/BRIEF.md
# Wishbone Single-Transfer Master with Byte-Lane Steering

This block sits between a simple processor-side request port and a Wishbone classic bus. A one-cycle start request carries an address, write data, a direction flag and an access size (byte, halfword or word). The block turns it into exactly one bus cycle and reports completion with a one-cycle done pulse. For reads, the response data is returned with that pulse.

The bus data path is 32 bits wide. The slave behind it may implement only 8, 16 or 32 of those bits, as set by the `SLAVE_W` parameter. The block works out which byte lanes the access occupies from the slave width, the access size and the low address bits. It drives those lanes on the select output and moves the write data onto them. On reads it takes the same lanes from the incoming bus data, shifts them down to bit 0 and zero-extends the result. An access that is wider than the slave is clipped to the slave width.

The block starts at most one transfer at a time. A start request that arrives while a cycle is still waiting for acknowledge is dropped.

Top module: `wb_lane_master`

## Requirements
- R1: While `rst_ni` is low, `wb_cyc_o`, `wb_stb_o` and `rsp_done_o` are low and `rsp_rdata_o` is zero. An active reset in the middle of a cycle ends that cycle at once.
- R2: When idle, a high `req_start_i` at a clock edge raises `wb_cyc_o` and `wb_stb_o` together on that edge.
- R3: From the edge that starts a cycle until the edge that samples `wb_ack_i`, the outputs `wb_adr_o`, `wb_we_o`, `wb_sel_o` and `wb_dat_o` hold the values of that request. `wb_adr_o` is the full request address, and `wb_we_o` is 1 for a write and 0 for a read.
- R4: `wb_cyc_o` and `wb_stb_o` stay high until `wb_ack_i` is sampled high. On that edge both fall and `rsp_done_o` goes high for exactly one cycle. Writes and reads both produce this pulse.
- R5: The size code is 0 for byte, 1 for halfword, and 2 or 3 for word. With `SLAVE_W`=32, a byte selects lane `addr[1:0]` (`wb_sel_o` = 1<<addr[1:0]). A halfword selects `4'b0011` when addr[1] is 0 and `4'b1100` when it is 1. A word selects `4'b1111`.
- R6: With `SLAVE_W`=16, a byte selects lane `addr[0]`. A halfword or word is clipped to one halfword on lanes 0 and 1 (`4'b0011`).
- R7: With `SLAVE_W`=8, every access is one byte on lane 0 (`wb_sel_o` = `4'b0001`).
- R8: On writes, the low 8/16/32 bits of `req_wdata_i`, matching the effective size, appear on the selected lanes of `wb_dat_o`. Unselected lanes are zero.
- R9: On a read, `wb_dat_i` is captured on the edge where `wb_ack_i` is sampled. The selected lanes are right-aligned and zero-extended on `rsp_rdata_o`, which is valid with `rsp_done_o` and holds until the next read completes. Writes leave it unchanged.
- R10: A `req_start_i` is ignored while a cycle is open, including the cycle in which `wb_ack_i` arrives. It changes neither the bus outputs nor the cycle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Start request pulse |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_wdata_i | input | 32 | Write data, right-aligned |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| rsp_rdata_o | output | 32 | Right-aligned, zero-extended read data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| wb_adr_o | output | ADDR_W | Bus address |
| wb_dat_o | output | 32 | Bus write data on the selected lanes |
| wb_we_o | output | 1 | Bus write enable |
| wb_sel_o | output | 4 | Bus byte-lane select |
| wb_stb_o | output | 1 | Bus strobe |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
Two events can land in the same clock: the acknowledge that closes the open cycle and a new start request. The bench drives `req_start_i`, carrying a different address and direction, in the very cycle in which it raises `wb_ack_i`. That start must be dropped: the bench expects the cycle to close and `wb_cyc_o` to stay low afterwards.

It also places a start in the first cycle after the acknowledge, while `rsp_done_o` is high. That one must be accepted back-to-back. A reference model of the bus evaluates every edge against all three slave widths and judges both cases.

// File: rtl/wb_lane_pkg.sv
package wb_lane_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  function automatic logic [LANES-1:0] lane_mask(size_e s);
    case (s)
      SZ_BYTE: lane_mask = 4'b0001;
      SZ_HALF: lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] lane_expand(logic [LANES-1:0] m);
    for (int i = 0; i < LANES; i++) lane_expand[8*i +: 8] = {8{m[i]}};
  endfunction
endpackage

// File: rtl/wb_lane_steer.sv
module wb_lane_steer
  import wb_lane_pkg::*;
#(
  parameter int SLAVE_W = 32
) (
  input  logic [1:0]       addr_lo_i,
  input  logic [1:0]       size_i,
  input  logic [BUS_W-1:0] wdata_i,
  output size_e            eff_o,
  output logic [1:0]       off_o,
  output logic [LANES-1:0] sel_o,
  output logic [BUS_W-1:0] dat_o
);
  localparam logic [LANES-1:0] SLAVE_LANES = LANES'((1 << (SLAVE_W / 8)) - 1);

  size_e req;
  assign req = (size_i == 2'b11) ? SZ_WORD : size_e'(size_i);

  generate
    if (SLAVE_W == 8) begin : g_w8
      assign eff_o = SZ_BYTE;
      assign off_o = 2'b00;
    end else if (SLAVE_W == 16) begin : g_w16
      assign eff_o = (req == SZ_BYTE) ? SZ_BYTE : SZ_HALF;
      assign off_o = (req == SZ_BYTE) ? {1'b0, addr_lo_i[0]} : 2'b00;
    end else begin : g_w32
      assign eff_o = req;
      always_comb begin
        case (req)
          SZ_BYTE: off_o = addr_lo_i;
          SZ_HALF: off_o = {addr_lo_i[1], 1'b0};
          default: off_o = 2'b00;
        endcase
      end
    end
  endgenerate

  assign sel_o = lane_mask(eff_o) << off_o;
  assign dat_o = (wdata_i & lane_expand(lane_mask(eff_o))) << {off_o, 3'b000};

  // lanes beyond the slave width must never be selected
  always_comb begin
    assert_sel_in_slave_R7: assert ((sel_o & ~SLAVE_LANES) == '0);
  end
endmodule

// File: rtl/wb_lane_extract.sv
module wb_lane_extract
  import wb_lane_pkg::*;
(
  input  logic [BUS_W-1:0] bus_i,
  input  logic [1:0]       off_i,
  input  size_e            eff_i,
  output logic [BUS_W-1:0] data_o
);
  assign data_o = (bus_i >> {off_i, 3'b000}) & lane_expand(lane_mask(eff_i));
endmodule

// File: rtl/wb_lane_ctrl.sv
module wb_lane_ctrl
  import wb_lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  dat_i,
  input  logic [LANES-1:0]  sel_i,
  input  logic [1:0]        off_i,
  input  size_e             eff_i,
  input  logic              ack_i,
  input  logic [BUS_W-1:0]  rd_aligned_i,
  output logic              cyc_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [BUS_W-1:0]  dat_o,
  output logic              we_o,
  output logic [LANES-1:0]  sel_o,
  output logic [1:0]        off_o,
  output size_e             eff_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic launch;
  assign launch = start_i && !cyc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o   <= 1'b0;
      done_o  <= 1'b0;
      adr_o   <= '0;
      dat_o   <= '0;
      we_o    <= 1'b0;
      sel_o   <= '0;
      off_o   <= '0;
      eff_o   <= SZ_BYTE;
      rdata_o <= '0;
    end else begin
      done_o <= cyc_o && ack_i;
      if (launch) begin
        cyc_o <= 1'b1;
        adr_o <= addr_i;
        dat_o <= dat_i;
        we_o  <= we_i;
        sel_o <= sel_i;
        off_o <= off_i;
        eff_o <= eff_i;
      end else if (cyc_o && ack_i) begin
        cyc_o <= 1'b0;
        if (!we_o) rdata_o <= rd_aligned_i;
      end
    end
  end

  assert_launch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_o && start_i) |=> cyc_o);

  assert_hold_fields_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && !ack_i) |=> (cyc_o && $stable(adr_o) && $stable(dat_o) && $stable(we_o) && $stable(sel_o)));

  assert_end_on_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && ack_i) |=> (!cyc_o && done_o));

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_write_keeps_rdata_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && we_o) |=> $stable(rdata_o));

  assert_busy_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && start_i) |=> ($stable(adr_o) && $stable(we_o)));
endmodule

// File: rtl/wb_lane_master.sv
module wb_lane_master
  import wb_lane_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SLAVE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_start_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic              req_we_i,
  input  logic [1:0]        req_size_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_done_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [31:0]       wb_dat_o,
  output logic              wb_we_o,
  output logic [3:0]        wb_sel_o,
  output logic              wb_stb_o,
  output logic              wb_cyc_o,
  input  logic [31:0]       wb_dat_i,
  input  logic              wb_ack_i
);
  size_e            st_eff, q_eff;
  logic [1:0]       st_off, q_off;
  logic [LANES-1:0] st_sel;
  logic [BUS_W-1:0] st_dat, rd_aligned;
  logic             cyc;

  wb_lane_steer #(.SLAVE_W(SLAVE_W)) u_steer (
    .addr_lo_i (req_addr_i[1:0]),
    .size_i    (req_size_i),
    .wdata_i   (req_wdata_i),
    .eff_o     (st_eff),
    .off_o     (st_off),
    .sel_o     (st_sel),
    .dat_o     (st_dat)
  );

  wb_lane_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (req_start_i),
    .addr_i       (req_addr_i),
    .we_i         (req_we_i),
    .dat_i        (st_dat),
    .sel_i        (st_sel),
    .off_i        (st_off),
    .eff_i        (st_eff),
    .ack_i        (wb_ack_i),
    .rd_aligned_i (rd_aligned),
    .cyc_o        (cyc),
    .done_o       (rsp_done_o),
    .adr_o        (wb_adr_o),
    .dat_o        (wb_dat_o),
    .we_o         (wb_we_o),
    .sel_o        (wb_sel_o),
    .off_o        (q_off),
    .eff_o        (q_eff),
    .rdata_o      (rsp_rdata_o)
  );

  wb_lane_extract u_extract (
    .bus_i  (wb_dat_i),
    .off_i  (q_off),
    .eff_i  (q_eff),
    .data_o (rd_aligned)
  );

  assign wb_cyc_o = cyc;
  assign wb_stb_o = cyc;

  assert_byte_read_zext_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && !wb_we_o && q_eff == SZ_BYTE) |-> (rsp_rdata_o[31:8] == 24'h0));
endmodule

// File: tb/wb_lane_master_tb.sv
`timescale 1ns/1ps
module wb_lane_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] bus_rd = 32'hBAD0_BAD0;
  logic        ack = 1'b0;

  logic [31:0] rd_o  [3];
  logic        done_o[3];
  logic [31:0] adr_o [3];
  logic [31:0] dat_o [3];
  logic        we_o  [3];
  logic [3:0]  sel_o [3];
  logic        stb_o [3];
  logic        cyc_o [3];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  // index 0: 8-bit slave, 1: 16-bit, 2: 32-bit
  wb_lane_master #(.ADDR_W(32), .SLAVE_W(8)) u_dut8 (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_we_i(we), .req_size_i(size),
    .rsp_rdata_o(rd_o[0]), .rsp_done_o(done_o[0]), .wb_adr_o(adr_o[0]),
    .wb_dat_o(dat_o[0]), .wb_we_o(we_o[0]), .wb_sel_o(sel_o[0]),
    .wb_stb_o(stb_o[0]), .wb_cyc_o(cyc_o[0]), .wb_dat_i(bus_rd), .wb_ack_i(ack));

  wb_lane_master #(.ADDR_W(32), .SLAVE_W(16)) u_dut16 (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_we_i(we), .req_size_i(size),
    .rsp_rdata_o(rd_o[1]), .rsp_done_o(done_o[1]), .wb_adr_o(adr_o[1]),
    .wb_dat_o(dat_o[1]), .wb_we_o(we_o[1]), .wb_sel_o(sel_o[1]),
    .wb_stb_o(stb_o[1]), .wb_cyc_o(cyc_o[1]), .wb_dat_i(bus_rd), .wb_ack_i(ack));

  wb_lane_master #(.ADDR_W(32), .SLAVE_W(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_start_i(start), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_we_i(we), .req_size_i(size),
    .rsp_rdata_o(rd_o[2]), .rsp_done_o(done_o[2]), .wb_adr_o(adr_o[2]),
    .wb_dat_o(dat_o[2]), .wb_we_o(we_o[2]), .wb_sel_o(sel_o[2]),
    .wb_stb_o(stb_o[2]), .wb_cyc_o(cyc_o[2]), .wb_dat_i(bus_rd), .wb_ack_i(ack));

  // ---------------- reference model ----------------
  bit          m_busy = 0;
  bit          m_done = 0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_wd = '0;
  bit          m_we = 0;
  logic [1:0]  m_sz = '0;
  logic [31:0] m_rd[3] = '{32'h0, 32'h0, 32'h0};

  function automatic int eff_bytes(int k, logic [1:0] sz);
    int e = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    int sb = 1 << k;
    if (e > sb) e = sb;
    return e;
  endfunction

  function automatic int lane_off(int k, logic [31:0] a, logic [1:0] sz);
    int e = eff_bytes(k, sz);
    int lo = int'(a[1:0]) % (1 << k);
    return (lo / e) * e;
  endfunction

  function automatic logic [63:0] bytes_mask(int e);
    return (64'd1 << (8 * e)) - 64'd1;
  endfunction

  function automatic logic [3:0] exp_sel(int k, logic [31:0] a, logic [1:0] sz);
    int e = eff_bytes(k, sz);
    return 4'(((1 << e) - 1) << lane_off(k, a, sz));
  endfunction

  function automatic logic [31:0] exp_wdat(int k, logic [31:0] a, logic [1:0] sz, logic [31:0] d);
    logic [63:0] v = ({32'h0, d} & bytes_mask(eff_bytes(k, sz))) << (8 * lane_off(k, a, sz));
    return v[31:0];
  endfunction

  function automatic logic [31:0] exp_rdat(int k, logic [31:0] a, logic [1:0] sz, logic [31:0] b);
    logic [63:0] v = ({32'h0, b} >> (8 * lane_off(k, a, sz))) & bytes_mask(eff_bytes(k, sz));
    return v[31:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0;
      m_done = 0;
      for (int k = 0; k < 3; k++) m_rd[k] = '0;
    end else begin
      m_done = m_busy && ack;
      if (!m_busy && start) begin
        m_busy = 1;
        m_addr = addr;
        m_wd = wdata;
        m_we = we;
        m_sz = size;
      end else if (m_busy && ack) begin
        m_busy = 0;
        if (!m_we)
          for (int k = 0; k < 3; k++) m_rd[k] = exp_rdat(k, m_addr, m_sz, bus_rd);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
    end
  endtask

  // compare every cycle, 3 ns after the rising edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      for (int k = 0; k < 3; k++) begin
        chk({31'h0, cyc_o[k]}, {31'h0, m_busy}, $sformatf("R4 cyc w%0d", 8 << k));
        chk({31'h0, stb_o[k]}, {31'h0, m_busy}, $sformatf("R2 stb w%0d", 8 << k));
        chk({31'h0, done_o[k]}, {31'h0, m_done}, $sformatf("R4 done w%0d", 8 << k));
        chk(rd_o[k], m_rd[k], $sformatf("R9 rdata w%0d", 8 << k));
        if (m_busy) begin
          chk(adr_o[k], m_addr, $sformatf("R3 adr w%0d", 8 << k));
          chk({31'h0, we_o[k]}, {31'h0, m_we}, $sformatf("R3 we w%0d", 8 << k));
          chk({28'h0, sel_o[k]}, {28'h0, exp_sel(k, m_addr, m_sz)},
              $sformatf("%s sel w%0d", (k == 2) ? "R5" : (k == 1) ? "R6" : "R7", 8 << k));
          if (m_we)
            chk(dat_o[k], exp_wdat(k, m_addr, m_sz, m_wd), $sformatf("R8 wdat w%0d", 8 << k));
        end
      end
    end
  end

  // caller is at a falling edge; returns at the falling edge where done is high
  task automatic xfer(input logic [31:0] a, input logic [31:0] d, input bit w,
                      input logic [1:0] sz, input int lat, input logic [31:0] rd,
                      input bit poke, input bit start_on_ack);
    start = 1; addr = a; wdata = d; we = w; size = sz;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < lat; i++) begin
      if (poke && i == 0) begin
        start = 1; addr = 32'hFFFF_FFF0; we = ~w; size = 2'd2;
      end
      @(negedge clk);
      if (poke && i == 0) begin
        start = 0;
        chk(adr_o[2], a, "R10 adr kept after busy start");
      end
    end
    ack = 1; bus_rd = rd;
    if (start_on_ack) begin
      start = 1; addr = 32'h0000_0F00; we = ~w; size = 2'd0;
    end
    @(negedge clk);
    ack = 0; bus_rd = 32'hBAD0_BAD0; start = 0;
    if (start_on_ack) chk({31'h0, cyc_o[2]}, 32'h0, "R10 start with ack ignored");
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    for (int k = 0; k < 3; k++) begin
      chk({31'h0, cyc_o[k]}, 32'h0, "R1 cyc in reset");
      chk({31'h0, stb_o[k]}, 32'h0, "R1 stb in reset");
      chk({31'h0, done_o[k]}, 32'h0, "R1 done in reset");
      chk(rd_o[k], 32'h0, "R1 rdata in reset");
    end
    rst_n = 1;
    idle(2);

    // R2/R8 word write, immediate ack
    xfer(32'h100, 32'h1234_5678, 1, 2'd2, 0, 32'h0, 0, 0);
    idle(1);
    // R9 word read with wait states
    xfer(32'h104, 32'h0, 0, 2'd2, 2, 32'hA1B2_C3D4, 0, 0);
    idle(1);
    // R5/R6/R7 byte writes and reads on every offset
    for (int o = 0; o < 4; o++) begin
      xfer(32'h200 + o, 32'hDEAD_BE5A + o, 1, 2'd0, 1, 32'h0, 0, 0);
      xfer(32'h300 + o, 32'h0, 0, 2'd0, o, 32'h1122_3344, 0, 0);
    end
    idle(2);
    // halfwords, including odd addresses
    for (int o = 0; o < 4; o++) begin
      xfer(32'h400 + o, 32'hCAFE_F00D, 1, 2'd1, 0, 32'h0, 0, 0);
      xfer(32'h500 + o, 32'h0, 0, 2'd1, 1, 32'h8899_AABB, 0, 0);
    end
    // size code 3 behaves as word
    xfer(32'h602, 32'h0, 0, 2'd3, 1, 32'h5566_7788, 0, 0);
    // R9 write after read leaves read data
    xfer(32'h700, 32'hFFFF_FFFF, 1, 2'd2, 1, 32'h0, 0, 0);
    idle(1);
    // R10 start while waiting, and start in the ack cycle
    xfer(32'h800, 32'h0, 0, 2'd0, 3, 32'h0000_7F00, 1, 0);
    idle(1);
    xfer(32'h901, 32'hABCD_EF01, 1, 2'd1, 2, 32'h0, 0, 1);
    idle(2);
    // back-to-back: next start in the done cycle
    xfer(32'hA03, 32'h0, 0, 2'd0, 1, 32'hFE00_0000, 0, 0);
    xfer(32'hA02, 32'h0, 0, 2'd1, 0, 32'h1357_9BDF, 0, 0);
    idle(2);

    // R1 reset in the middle of a cycle
    start = 1; addr = 32'hB00; we = 0; size = 2'd2;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    chk({31'h0, cyc_o[2]}, 32'h0, "R1 cyc dropped by reset");
    chk(rd_o[2], 32'h0, "R1 rdata cleared by reset");
    idle(2);
    rst_n = 1;
    idle(1);
    xfer(32'hC01, 32'h0, 0, 2'd0, 1, 32'h0000_9900, 0, 0);
    idle(3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule